// File: doc/BRIEF.md
# PC-Relative Address Generator

This unit sits in the execute stage next to the integer ALU. It takes the program counter of an instruction and that instruction's 21-bit immediate, and it works out what the instruction needs. The immediate carries its own sub-opcode in its upper bits. That sub-opcode is decoded by longest prefix: first the top five bits are checked, then the top three, then the top two. Each sub-operation uses its own offset width, scale and alignment.

Some sub-operations are pure arithmetic. For these the unit produces a 64-bit result for the destination register. The others are loads. For these it issues a load request with an address, a size (word or doubleword) and a signedness. The memory access itself happens outside the block. An encoding that matches no sub-operation raises an illegal-operation flag and causes neither a register write nor a load.

All outputs are registered. They appear one clock after the operation is presented, and a new operation may be presented every cycle.

Top module: `pcrel_agen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid, out_wr, out_ld and out_illegal are all 0.
- R2: Prefix 5'b11110 in imm[20:16] returns PC + (imm[15:0] sign-extended, shifted left by 16) on out_result, with out_wr=1.
- R3: Prefix 5'b11111 in imm[20:16] returns the same sum as R2 with bits [15:0] cleared, with out_wr=1.
- R4: Prefix 3'b110 in imm[20:18] requests a doubleword load (out_ld=1, out_ld_dword=1). Its address is (PC with bits [2:0] cleared) + (imm[17:0] sign-extended from bit 17, shifted left by 3).
- R5: Prefix 2'b01 in imm[20:19] requests a signed word load (out_ld_dword=0, out_ld_signed=1) at PC + (imm[18:0] sign-extended from bit 18, shifted left by 2).
- R6: Prefix 2'b10 in imm[20:19] requests an unsigned word load (out_ld_signed=0) at the same address as R5.
- R7: Prefix 2'b00 in imm[20:19] returns PC + (imm[18:0] sign-extended from bit 18, shifted left by 2) on out_result, with out_wr=1.
- R8: Prefixes 5'b11100 and 5'b11101 set out_illegal=1, with out_wr=0, out_ld=0 and out_result=0.
- R9: Outputs appear exactly one clock after in_valid. A cycle with in_valid=0 gives out_valid=0, out_wr=0 and out_ld=0 on the next clock.
- R10: out_dst equals the in_dst given with the operation, for both writes and loads.
- R11: Whenever out_valid=1, exactly one of out_wr, out_ld and out_illegal is 1.
- R12: Negative offsets and the most negative and most positive offsets of each width are handled with correct sign extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_pc | input | 64 | PC of the operation |
| in_imm | input | 21 | Immediate with its sub-opcode prefix |
| in_dst | input | 5 | Destination register index |
| out_valid | output | 1 | Registered outputs hold an operation |
| out_wr | output | 1 | Write out_result to the destination register |
| out_result | output | 64 | Arithmetic result |
| out_dst | output | 5 | Destination register index |
| out_ld | output | 1 | Load request |
| out_ld_addr | output | 64 | Load address |
| out_ld_dword | output | 1 | 1 for a doubleword load, 0 for a word load |
| out_ld_signed | output | 1 | Word load result is sign-extended when 1 |
| out_illegal | output | 1 | Encoding matched no sub-operation |

## Verification
A register-write outcome and a load-request outcome can be on the output stage in consecutive cycles, with one leaving as the next arrives. Likewise, a new operation is accepted in the same cycle that the previous one's result is presented. The bench provokes both by streaming its vector table with in_valid held high. Arithmetic, load and illegal encodings are interleaved, so each output cycle is judged against the vector presented just one clock before it. Any carry-over of a flag from the previous operation shows up as a second asserted action or as a wrong address or result.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;

    typedef enum logic [2:0] {
        OP_UPPER,
        OP_UPPER_ALN,
        OP_LOAD_D,
        OP_LOAD_W,
        OP_LOAD_WU,
        OP_ADD_OFS,
        OP_BAD
    } pcrel_op_t;

    localparam int IMM_W = 21;

    // Prefix codes: their bit positions are decoded by the rest of the unit.
    localparam logic [4:0] PFX5_UPPER     = 5'b11110;
    localparam logic [4:0] PFX5_UPPER_ALN = 5'b11111;
    localparam logic [2:0] PFX3_LOAD_D    = 3'b110;
    localparam logic [1:0] PFX2_ADD_OFS   = 2'b00;
    localparam logic [1:0] PFX2_LOAD_W    = 2'b01;
    localparam logic [1:0] PFX2_LOAD_WU   = 2'b10;

endpackage

// File: rtl/pcrel_decode.sv
module pcrel_decode
    import pcrel_pkg::*;
(
    input  logic [IMM_W-1:0] imm,
    output pcrel_op_t        op
);
    localparam int TOP = IMM_W - 1;

    logic [4:0] pfx5;
    logic [2:0] pfx3;
    logic [1:0] pfx2;

    assign pfx5 = imm[TOP -: 5];
    assign pfx3 = imm[TOP -: 3];
    assign pfx2 = imm[TOP -: 2];

    // Longest prefix first, shorter ones only when the longer fail.
    always_comb begin
        op = OP_BAD;
        if (pfx5 == PFX5_UPPER) begin
            op = OP_UPPER;
        end else if (pfx5 == PFX5_UPPER_ALN) begin
            op = OP_UPPER_ALN;
        end else if (pfx3 == PFX3_LOAD_D) begin
            op = OP_LOAD_D;
        end else begin
            unique case (pfx2)
                PFX2_ADD_OFS: op = OP_ADD_OFS;
                PFX2_LOAD_W:  op = OP_LOAD_W;
                PFX2_LOAD_WU: op = OP_LOAD_WU;
                default:      op = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/pcrel_calc.sv
module pcrel_calc
    import pcrel_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  pcrel_op_t        op,
    input  logic [PC_W-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    output logic [PC_W-1:0]  result,
    output logic [PC_W-1:0]  ld_addr
);
    localparam int U_W  = 16;
    localparam int U_SH = 16;
    localparam int D_W  = 18;
    localparam int D_SH = 3;
    localparam int W_W  = 19;
    localparam int W_SH = 2;

    logic [PC_W-1:0] ofs_upper;
    logic [PC_W-1:0] ofs_dword;
    logic [PC_W-1:0] ofs_word;
    logic [PC_W-1:0] sum_upper;
    logic [PC_W-1:0] sum_word;
    logic [PC_W-1:0] pc_d_base;

    assign ofs_upper = {{(PC_W-U_W){imm[U_W-1]}}, imm[U_W-1:0]} << U_SH;
    assign ofs_dword = {{(PC_W-D_W){imm[D_W-1]}}, imm[D_W-1:0]} << D_SH;
    assign ofs_word  = {{(PC_W-W_W){imm[W_W-1]}}, imm[W_W-1:0]} << W_SH;

    assign sum_upper = pc + ofs_upper;
    assign sum_word  = pc + ofs_word;
    assign pc_d_base = {pc[PC_W-1:D_SH], {D_SH{1'b0}}};

    always_comb begin
        result  = '0;
        ld_addr = '0;
        unique case (op)
            OP_UPPER:     result  = sum_upper;
            OP_UPPER_ALN: result  = {sum_upper[PC_W-1:U_SH], {U_SH{1'b0}}};
            OP_ADD_OFS:   result  = sum_word;
            OP_LOAD_D:    ld_addr = pc_d_base + ofs_dword;
            OP_LOAD_W,
            OP_LOAD_WU:   ld_addr = sum_word;
            default: ;
        endcase
    end

    always_comb begin
        if (op == OP_UPPER_ALN) begin
            assert (result[U_SH-1:0] == '0 && result[PC_W-1:U_SH] == sum_upper[PC_W-1:U_SH]); // R3
        end
        if (op == OP_LOAD_D) begin
            assert (ld_addr[D_SH-1:0] == '0); // R4
        end
    end
endmodule

// File: rtl/pcrel_agen.sv
module pcrel_agen
    import pcrel_pkg::*;
#(
    parameter int PC_W  = 64,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PC_W-1:0]  in_pc,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [REG_W-1:0] in_dst,
    output logic             out_valid,
    output logic             out_wr,
    output logic [PC_W-1:0]  out_result,
    output logic [REG_W-1:0] out_dst,
    output logic             out_ld,
    output logic [PC_W-1:0]  out_ld_addr,
    output logic             out_ld_dword,
    output logic             out_ld_signed,
    output logic             out_illegal
);
    typedef struct packed {
        logic             vld;
        logic             wr;
        logic             ld;
        logic             dword;
        logic             sgn;
        logic             ill;
        logic [REG_W-1:0] dst;
        logic [PC_W-1:0]  res;
        logic [PC_W-1:0]  addr;
    } stage_t;

    pcrel_op_t       op;
    logic [PC_W-1:0] calc_res;
    logic [PC_W-1:0] calc_addr;
    stage_t          st_d, st_q;

    pcrel_decode i_dec (
        .imm (in_imm),
        .op  (op)
    );

    pcrel_calc #(.PC_W(PC_W)) i_calc (
        .op      (op),
        .pc      (in_pc),
        .imm     (in_imm),
        .result  (calc_res),
        .ld_addr (calc_addr)
    );

    always_comb begin
        st_d       = '0;
        st_d.vld   = in_valid;
        st_d.dst   = in_dst;
        if (in_valid) begin
            st_d.wr    = (op == OP_UPPER) || (op == OP_UPPER_ALN) || (op == OP_ADD_OFS);
            st_d.ld    = (op == OP_LOAD_D) || (op == OP_LOAD_W) || (op == OP_LOAD_WU);
            st_d.ill   = (op == OP_BAD);
            st_d.dword = (op == OP_LOAD_D);
            st_d.sgn   = (op == OP_LOAD_W);
            st_d.res   = calc_res;
            st_d.addr  = calc_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid     = st_q.vld;
    assign out_wr        = st_q.wr;
    assign out_result    = st_q.res;
    assign out_dst       = st_q.dst;
    assign out_ld        = st_q.ld;
    assign out_ld_addr   = st_q.addr;
    assign out_ld_dword  = st_q.dword;
    assign out_ld_signed = st_q.sgn;
    assign out_illegal   = st_q.ill;

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones({out_wr, out_ld, out_illegal}) == 1); // R11

    AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_wr && !out_ld); // R9

    AST_DST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_dst == $past(in_dst)); // R10

    AST_BAD_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_imm[IMM_W-1 -: 4] == 4'b1110 |=> out_illegal && !out_ld && !out_wr); // R8

    AST_DWORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        out_ld && out_ld_dword |-> out_ld_addr[2:0] == 3'b000); // R4
endmodule

// File: tb/test_pcrel_agen.sv
module test_pcrel_agen;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    // kind: 0 = register write, 1 = load, 2 = illegal
    typedef struct packed {
        logic [63:0] pc;
        logic [20:0] imm;
        logic [4:0]  dst;
        logic [1:0]  kind;
        logic [63:0] val;
        logic        dword;
        logic        sgn;
    } vec_t;

    localparam logic [63:0] PC0 = 64'h1000_0000_0000_1234;

    localparam vec_t VECS [NV] = '{
        '{PC0, 21'h1E0002, 5'd5,  2'd0, 64'h1000_0000_0002_1234, 1'b0, 1'b0}, // R2
        '{PC0, 21'h1EFFFF, 5'd6,  2'd0, 64'h0FFF_FFFF_FFFF_1234, 1'b0, 1'b0}, // R2 R12
        '{PC0, 21'h1F0001, 5'd7,  2'd0, 64'h1000_0000_0001_0000, 1'b0, 1'b0}, // R3
        '{PC0, 21'h180004, 5'd8,  2'd1, 64'h1000_0000_0000_1250, 1'b1, 1'b0}, // R4
        '{PC0, 21'h1BFFFF, 5'd9,  2'd1, 64'h1000_0000_0000_1228, 1'b1, 1'b0}, // R4 R12
        '{PC0, 21'h080010, 5'd10, 2'd1, 64'h1000_0000_0000_1274, 1'b0, 1'b1}, // R5
        '{PC0, 21'h17FFFF, 5'd11, 2'd1, 64'h1000_0000_0000_1230, 1'b0, 1'b0}, // R6 R12
        '{PC0, 21'h000100, 5'd12, 2'd0, 64'h1000_0000_0000_1634, 1'b0, 1'b0}, // R7
        '{PC0, 21'h040000, 5'd13, 2'd0, 64'h0FFF_FFFF_FFF0_1234, 1'b0, 1'b0}, // R7 R12
        '{PC0, 21'h1C1234, 5'd14, 2'd2, 64'h0,                    1'b0, 1'b0}, // R8
        '{64'h0, 21'h19FFFF, 5'd15, 2'd1, 64'h0000_0000_000F_FFF8, 1'b1, 1'b0}, // R4 R12
        '{PC0, 21'h1D0000, 5'd16, 2'd2, 64'h0,                    1'b0, 1'b0}, // R8
        '{64'hFFFF_FFFF_FFFF_FFFC, 21'h03FFFF, 5'd31, 2'd0, 64'h0000_0000_000F_FFF8, 1'b0, 1'b0} // R7 R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_pc = '0;
    logic [20:0] in_imm = '0;
    logic [4:0]  in_dst = '0;
    logic        out_valid, out_wr, out_ld, out_ld_dword, out_ld_signed, out_illegal;
    logic [63:0] out_result, out_ld_addr;
    logic [4:0]  out_dst;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcrel_agen i_pcrel_agen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
        .in_imm(in_imm), .in_dst(in_dst), .out_valid(out_valid), .out_wr(out_wr),
        .out_result(out_result), .out_dst(out_dst), .out_ld(out_ld),
        .out_ld_addr(out_ld_addr), .out_ld_dword(out_ld_dword),
        .out_ld_signed(out_ld_signed), .out_illegal(out_illegal)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_vec(input vec_t v, input int idx);
        string tag;
        tag = $sformatf("R9/R11 vec%0d", idx);
        check(tag, {61'b0, out_wr, out_ld, out_illegal},
              {61'b0, v.kind == 2'd0, v.kind == 2'd1, v.kind == 2'd2});
        check($sformatf("R10 vec%0d dst", idx), {59'b0, out_dst}, {59'b0, v.dst});
        check($sformatf("R9 vec%0d valid", idx), {63'b0, out_valid}, 64'd1);
        if (v.kind == 2'd0) begin
            check($sformatf("R2/R3/R7 vec%0d result", idx), out_result, v.val);
        end else if (v.kind == 2'd1) begin
            check($sformatf("R4/R5/R6 vec%0d addr", idx), out_ld_addr, v.val);
            check($sformatf("R4/R5 vec%0d size", idx), {63'b0, out_ld_dword}, {63'b0, v.dword});
            check($sformatf("R5/R6 vec%0d signed", idx), {63'b0, out_ld_signed}, {63'b0, v.sgn});
        end else begin
            check($sformatf("R8 vec%0d result", idx), out_result, 64'h0);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1 flags in reset", {60'b0, out_valid, out_wr, out_ld, out_illegal}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after reset", {60'b0, out_valid, out_wr, out_ld, out_illegal}, 64'h0);

        // Streamed table: one vector per cycle, result one clock later (R9)
        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            in_pc    = VECS[i].pc;
            in_imm   = VECS[i].imm;
            in_dst   = VECS[i].dst;
            @(negedge clk);
            check_vec(VECS[i], i);
        end

        // R9: an idle cycle with a load encoding on the inputs has no effect
        in_valid = 1'b0;
        in_imm   = 21'h180004;
        @(negedge clk);
        check("R9 idle", {61'b0, out_valid, out_wr, out_ld}, 64'h0);

        // R9: a single operation after the idle cycle, then idle again
        in_valid = 1'b1;
        in_pc    = PC0;
        in_imm   = 21'h1E0002;
        in_dst   = 5'd3;
        @(negedge clk);
        check("R2 after idle", out_result, 64'h1000_0000_0002_1234);
        check("R10 after idle", {59'b0, out_dst}, 64'd3);
        in_valid = 1'b0;
        @(negedge clk);
        check("R9 drop", {61'b0, out_valid, out_wr, out_ld}, 64'h0);

        // R1: reset in the middle of a stream clears the flags
        in_valid = 1'b1;
        in_imm   = 21'h1C0000;
        @(negedge clk);
        check("R8 illegal before reset", {63'b0, out_illegal}, 64'd1);
        rst_n = 1'b0;
        #1;
        check("R1 async clear", {60'b0, out_valid, out_wr, out_ld, out_illegal}, 64'h0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reassert", {60'b0, out_valid, out_wr, out_ld, out_illegal}, 64'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule